// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Edge Interrupts

The block is a register-mapped general-purpose I/O controller. Its 42 pins are grouped as four 8-bit ports and one 10-bit port. Each pin has its own direction and output value, its own interrupt mask, and its own edge polarity. Each port has a single function select. When the select is clear, the GPIO registers drive the pins. When it is set, an on-chip peripheral drives them instead. Pad inputs pass through a two-stage synchronizer. The synchronized value goes to the peripheral side and to the edge detectors.

An edge of the selected polarity latches a sticky status bit, and software clears that bit by writing 1 to it. The single interrupt request is the OR of every status bit whose mask bit is set. Software uses a simple request/write-enable bus. A register is addressed by a port index in the upper address bits and a register code in the low three bits. Read data appears one cycle after the read request.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset all pins are inputs (`pad_oe_o` all 0), `pad_out_o` is 0, `irq_o` is 0, and every register of every port reads 0 while the pads are held low.
- R2: With a port's function select clear, each `pad_oe_o` bit equals the corresponding direction bit (1 = drive) and each `pad_out_o` bit equals the output data bit.
- R3: Address = {port index, register code}; the port index is in `addr_i[5:3]` and the code is in `addr_i[2:0]`. Codes: 0 output data, 1 direction, 2 pin level (read-only), 3 interrupt mask, 4 interrupt polarity, 5 interrupt status, 6 function select (bit 0). Written values read back, and bits above a port's width read 0. `rdata_o` updates on the clock edge that samples a read request.
- R4: The pin-level register reflects a pad change after two clock edges, and not after one.
- R5: A status bit sets when its synchronized input goes 0→1 with polarity 1, or 1→0 with polarity 0. The opposite edge leaves it unchanged. An event shows in status three clock edges after the pad change.
- R6: Writing status clears the bits written as 1 and keeps the bits written as 0. If an edge event and a clearing write land on the same edge, the bit stays set.
- R7: `irq_o` is 1 exactly when some status bit is set with its mask bit 1. Masked bits still latch status.
- R8: With a port's function select set, that port's `pad_oe_o` and `pad_out_o` bits follow `alt_oe_i` and `alt_out_i`. Other ports are unaffected.
- R9: `alt_in_o` carries the synchronized pad level of every pin, whatever the direction or function select.
- R10: Writes to port indices 5–7, to register code 7, or to the pin-level register change nothing, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | {port index, register code} |
| wdata_i | input | 10 | Write data |
| rdata_o | output | 10 | Registered read data |
| pad_in_i | input | 42 | Pad input levels |
| pad_out_o | output | 42 | Pad output data |
| pad_oe_o | output | 42 | Pad output enable |
| alt_out_i | input | 42 | Peripheral output data |
| alt_oe_i | input | 42 | Peripheral output enable |
| alt_in_o | output | 42 | Synchronized pad levels to peripherals |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clearing write to the status register that lands on the same clock edge as a new edge event on that bit. The pad change must lead the write by exactly the synchronizer and edge-history latency. The stimulus changes a pad at a falling clock edge and lets two rising edges pass. It then presents the status write so that it is sampled on the third edge, and it repeats the write one cycle later to show that a normal clear takes effect. Every bit is also swept through a rising and a falling edge under each polarity, and a random pad walk is checked against an arithmetic status model.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [2:0] {
    REG_DOUT = 3'd0,
    REG_DIR  = 3'd1,
    REG_PIN  = 3'd2,
    REG_MASK = 3'd3,
    REG_POL  = 3'd4,
    REG_STAT = 3'd5,
    REG_FUNC = 3'd6
  } reg_sel_e;

  localparam int unsigned REG_AW = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] prev_q, stat_q, rise, fall, evt;

  assign rise = pin_i & ~prev_q;
  assign fall = ~pin_i & prev_q;
  assign evt  = (pol_i & rise) | (~pol_i & fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= pin_i;
      // new event wins over a same-cycle clear
      stat_q <= (stat_q & ~clr_i) | evt;
    end
  end

  assign stat_o = stat_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_sel_e          rsel_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      pin_i,
  input  logic [W-1:0]      alt_out_i,
  input  logic [W-1:0]      alt_oe_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [W-1:0]      pad_out_o,
  output logic [W-1:0]      pad_oe_o,
  output logic [W-1:0]      stat_o,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      prev_o,
  output logic              func_o
);
  logic [W-1:0] dout_q, dir_q, mask_q, pol_q, clr;
  logic         func_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      dir_q  <= '0;
      mask_q <= '0;
      pol_q  <= '0;
      func_q <= 1'b0;
    end else if (wr_i) begin
      case (rsel_i)
        REG_DOUT: dout_q <= wdata_i;
        REG_DIR:  dir_q  <= wdata_i;
        REG_MASK: mask_q <= wdata_i;
        REG_POL:  pol_q  <= wdata_i;
        REG_FUNC: func_q <= wdata_i[0];
        default:  ;
      endcase
    end
  end

  assign clr = (wr_i && rsel_i == REG_STAT) ? wdata_i : '0;

  gpio_edge #(.W(W)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .pol_i  (pol_q),
    .clr_i  (clr),
    .stat_o (stat_o),
    .prev_o (prev_o)
  );

  always_comb begin
    rdata_o = '0;
    case (rsel_i)
      REG_DOUT: rdata_o[W-1:0] = dout_q;
      REG_DIR:  rdata_o[W-1:0] = dir_q;
      REG_PIN:  rdata_o[W-1:0] = pin_i;
      REG_MASK: rdata_o[W-1:0] = mask_q;
      REG_POL:  rdata_o[W-1:0] = pol_q;
      REG_STAT: rdata_o[W-1:0] = stat_o;
      REG_FUNC: rdata_o[0]     = func_q;
      default:  ;
    endcase
  end

  // pin mux: peripheral owns the pads when the port's select is set
  assign pad_oe_o  = func_q ? alt_oe_i  : dir_q;
  assign pad_out_o = func_q ? alt_out_i : dout_q;

  assign mask_o = mask_q;
  assign dir_o  = dir_q;
  assign func_o = func_q;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter  int unsigned NUM_PORTS = 5,
  parameter  int unsigned BASE_W    = 8,
  parameter  int unsigned LAST_W    = 10,
  localparam int unsigned TOTAL_W   = BASE_W * (NUM_PORTS - 1) + LAST_W,
  localparam int unsigned DATA_W    = (LAST_W > BASE_W) ? LAST_W : BASE_W,
  localparam int unsigned PORT_AW   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned ADDR_W    = PORT_AW + REG_AW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [TOTAL_W-1:0] pad_in_i,
  output logic [TOTAL_W-1:0] pad_out_o,
  output logic [TOTAL_W-1:0] pad_oe_o,
  input  logic [TOTAL_W-1:0] alt_out_i,
  input  logic [TOTAL_W-1:0] alt_oe_i,
  output logic [TOTAL_W-1:0] alt_in_o,
  output logic               irq_o
);
  logic [TOTAL_W-1:0] sync_all, stat_all, mask_all, dir_all, prev_all, func_all;
  logic [DATA_W-1:0]  port_rdata [NUM_PORTS];
  logic [DATA_W-1:0]  rd_mux, rdata_q;
  logic [PORT_AW-1:0] port_idx;
  reg_sel_e           reg_sel;

  assign port_idx = addr_i[ADDR_W-1:REG_AW];
  assign reg_sel  = reg_sel_e'(addr_i[REG_AW-1:0]);

  gpio_sync #(.W(TOTAL_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (sync_all)
  );

  assign alt_in_o = sync_all;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int unsigned W  = (p == NUM_PORTS - 1) ? LAST_W : BASE_W;
    localparam int unsigned LO = p * BASE_W;
    logic sel, func_p;

    assign sel = (port_idx == PORT_AW'(p));

    gpio_port #(.W(W), .DATA_W(DATA_W)) u_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (req_i & we_i & sel),
      .rsel_i    (reg_sel),
      .wdata_i   (wdata_i[W-1:0]),
      .pin_i     (sync_all[LO +: W]),
      .alt_out_i (alt_out_i[LO +: W]),
      .alt_oe_i  (alt_oe_i[LO +: W]),
      .rdata_o   (port_rdata[p]),
      .pad_out_o (pad_out_o[LO +: W]),
      .pad_oe_o  (pad_oe_o[LO +: W]),
      .stat_o    (stat_all[LO +: W]),
      .mask_o    (mask_all[LO +: W]),
      .dir_o     (dir_all[LO +: W]),
      .prev_o    (prev_all[LO +: W]),
      .func_o    (func_p)
    );

    assign func_all[LO +: W] = {W{func_p}};
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (port_idx == PORT_AW'(p)) rd_mux = port_rdata[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_q <= '0;
    else if (req_i && !we_i)   rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(stat_all & mask_all);
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int unsigned TOTAL_W = 42
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic               irq_o,
  input logic [TOTAL_W-1:0] pad_oe_o,
  input logic [TOTAL_W-1:0] alt_oe_i,
  input logic [TOTAL_W-1:0] dir_all,
  input logic [TOTAL_W-1:0] func_all,
  input logic [TOTAL_W-1:0] stat_all,
  input logic [TOTAL_W-1:0] mask_all,
  input logic [TOTAL_W-1:0] sync_all,
  input logic [TOTAL_W-1:0] prev_all
);
  AST_OE_GPIO_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o ^ dir_all) & ~func_all) == '0); // R2

  AST_OE_ALT_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o ^ alt_oe_i) & func_all) == '0); // R8

  AST_IRQ_QUIET_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_all == '0) |-> !irq_o); // R7

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_all != '0)); // R7

  AST_STAT_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_all & ~$past(stat_all) & ~$past(sync_all ^ prev_all)) == '0); // R5

  AST_STAT_CLR_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(stat_all) & ~stat_all) != '0) |-> $past(req_i && we_i)); // R6
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.TOTAL_W(TOTAL_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .irq_o    (irq_o),
  .pad_oe_o (pad_oe_o),
  .alt_oe_i (alt_oe_i),
  .dir_all  (dir_all),
  .func_all (func_all),
  .stat_all (stat_all),
  .mask_all (mask_all),
  .sync_all (sync_all),
  .prev_all (prev_all)
);

// File: tb/tb_gpio_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_ctrl;
  localparam int C_DOUT = 0, C_DIR = 1, C_PIN = 2, C_MASK = 3, C_POL = 4, C_STAT = 5, C_FUNC = 6;
  localparam logic [41:0] ONES = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [9:0]  wdata = '0;
  logic [9:0]  rdata;
  logic [41:0] pad = '0, alt_out = '0, alt_oe = '0;
  logic [41:0] pad_out, pad_oe, alt_in;
  logic        irq;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  gpio_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .alt_out_i(alt_out), .alt_oe_i(alt_oe),
    .alt_in_o(alt_in), .irq_o(irq)
  );

  function automatic int pw(int p); return (p == 4) ? 10 : 8; endfunction
  function automatic logic [9:0] slice(logic [41:0] v, int p);
    return 10'((v >> (p * 8)) & ((42'd1 << pw(p)) - 1));
  endfunction

  task automatic chk(string req_s, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req_s, act, exp);
    end
  endtask

  task automatic wr(int p, int r, logic [9:0] d);
    @(negedge clk); req = 1; we = 1; addr = {p[2:0], r[2:0]}; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(int p, int r, output logic [9:0] d);
    @(negedge clk); req = 1; we = 0; addr = {p[2:0], r[2:0]};
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic wr_all(int r, logic [41:0] v);
    for (int p = 0; p < 5; p++) wr(p, r, slice(v, p));
  endtask

  task automatic rd_all(int r, output logic [41:0] v);
    logic [9:0] d;
    v = '0;
    for (int p = 0; p < 5; p++) begin
      rd(p, r, d);
      v = v | (42'(d) << (p * 8));
    end
  endtask

  task automatic wait_n(int n); repeat (n) @(negedge clk); endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [9:0]  d;
    logic [41:0] v, dirv, doutv, maskv, polv, fm, exp_s, old_p, nw, clr;
    logic [63:0] r64;

    wait_n(3);
    rst_n = 1;
    wait_n(1);
    // R1 reset state
    chk("R1 pad_oe", 64'(pad_oe), 0);
    chk("R1 pad_out", 64'(pad_out), 0);
    chk("R1 irq", 64'(irq), 0);
    for (int p = 0; p < 5; p++)
      for (int r = 0; r < 7; r++) begin
        rd(p, r, d);
        chk($sformatf("R1 reg p%0d c%0d", p, r), 64'(d), 0);
      end

    // R3 readback, R2 pin drive
    dirv = 42'h2A5_5AA3_C3C; doutv = 42'h1F3_0F0F_96E;
    maskv = 42'h3C3_A5A5_0FF; polv = 42'h0F0_F00F_5A3;
    wr_all(C_DIR, dirv); wr_all(C_DOUT, doutv);
    wr_all(C_MASK, maskv); wr_all(C_POL, polv);
    rd_all(C_DIR, v);  chk("R3 dir", 64'(v), 64'(dirv));
    rd_all(C_DOUT, v); chk("R3 dout", 64'(v), 64'(doutv));
    rd_all(C_MASK, v); chk("R3 mask", 64'(v), 64'(maskv));
    rd_all(C_POL, v);  chk("R3 pol", 64'(v), 64'(polv));
    chk("R2 pad_oe", 64'(pad_oe), 64'(dirv));
    chk("R2 pad_out", 64'(pad_out), 64'(doutv));
    wr(0, C_DIR, 10'h3FF); rd(0, C_DIR, d);
    chk("R3 narrow port upper bits", 64'(d), 64'h0FF);
    wr(0, C_DIR, slice(dirv, 0));

    // R10 unmapped writes and reads
    wr(5, C_DIR, 10'h3FF); wr(7, C_DOUT, 10'h3FF); wr(1, 7, 10'h3FF);
    wr_all(C_PIN, ONES);
    chk("R10 oe unchanged", 64'(pad_oe), 64'(dirv));
    chk("R10 out unchanged", 64'(pad_out), 64'(doutv));
    rd(5, C_DIR, d); chk("R10 read port5", 64'(d), 0);
    rd(1, 7, d);     chk("R10 read code7", 64'(d), 0);
    rd_all(C_PIN, v); chk("R10 pin reg not writable", 64'(v), 0);
    rd_all(C_DIR, v); chk("R10 dir intact", 64'(v), 64'(dirv));

    // R8 function select on ports 1 and 4
    alt_oe = 42'h155_5555_5555; alt_out = 42'h2CA_3355_AA0;
    wr(1, C_FUNC, 10'h001); wr(4, C_FUNC, 10'h001);
    fm = {10'h3FF, 8'h00, 8'h00, 8'hFF, 8'h00};
    chk("R8 pad_oe", 64'(pad_oe), 64'((alt_oe & fm) | (dirv & ~fm)));
    chk("R8 pad_out", 64'(pad_out), 64'((alt_out & fm) | (doutv & ~fm)));
    rd(1, C_FUNC, d); chk("R8 func readback", 64'(d), 1);
    rd(2, C_FUNC, d); chk("R8 func other port", 64'(d), 0);
    wr(1, C_FUNC, 10'h3FE); wr(4, C_FUNC, 10'h000);
    chk("R8 back to gpio", 64'(pad_oe), 64'(dirv));

    // R4/R9 synchronizer latency
    for (int k = 0; k < 6; k++) begin
      r64 = {$urandom, $urandom};
      v = (k % 2 == 0) ? r64[41:0] : ~pad;
      old_p = pad;
      pad = v;
      @(negedge clk);
      chk("R4 one edge not yet", 64'(alt_in), 64'(old_p));
      @(negedge clk);
      chk("R9 alt_in after two edges", 64'(alt_in), 64'(v));
      rd_all(C_PIN, nw);
      chk("R4 pin reg", 64'(nw), 64'(v));
    end
    pad = '0; wait_n(4);
    wr_all(C_STAT, ONES);
    rd_all(C_STAT, v); chk("R6 clear all", 64'(v), 0);

    // R5 per-bit edge sweep under each polarity
    wr_all(C_MASK, ONES);
    for (int ps = 0; ps < 2; ps++) begin
      wr_all(C_POL, ps ? ONES : '0);
      for (int b = 0; b < 42; b++) begin
        pad = 42'd1 << b; wait_n(4);
        rd_all(C_STAT, v);
        chk($sformatf("R5 rise b%0d pol%0d", b, ps), 64'(v), ps ? 64'(42'd1 << b) : 0);
        chk("R7 irq after rise", 64'(irq), 64'(ps));
        wr_all(C_STAT, ONES);
        pad = '0; wait_n(4);
        rd_all(C_STAT, v);
        chk($sformatf("R5 fall b%0d pol%0d", b, ps), 64'(v), ps ? 0 : 64'(42'd1 << b));
        wr_all(C_STAT, ONES);
      end
    end

    // R5/R6/R7 random walk against arithmetic model
    wr_all(C_POL, polv); wr_all(C_MASK, maskv);
    exp_s = '0; old_p = pad;
    for (int i = 0; i < 24; i++) begin
      r64 = {$urandom, $urandom};
      nw = r64[41:0];
      pad = nw; wait_n(4);
      exp_s = exp_s | (polv & nw & ~old_p) | (~polv & ~nw & old_p);
      old_p = nw;
      rd_all(C_STAT, v); chk("R5 model status", 64'(v), 64'(exp_s));
      chk("R7 irq model", 64'(irq), 64'(|(exp_s & maskv)));
      if (i % 4 == 3) begin
        r64 = {$urandom, $urandom};
        clr = r64[41:0];
        wr_all(C_STAT, clr);
        exp_s = exp_s & ~clr;
        rd_all(C_STAT, v); chk("R6 partial W1C", 64'(v), 64'(exp_s));
      end
    end
    pad = '0; wait_n(4); wr_all(C_STAT, ONES);

    // R7 masked bits still latch
    wr_all(C_MASK, '0); wr_all(C_POL, ONES);
    pad = 42'd1 << 35; wait_n(4);
    rd(4, C_STAT, d); chk("R7 masked latch", 64'(d), 64'h8);
    chk("R7 irq masked", 64'(irq), 0);
    wr(4, C_MASK, 10'h008);
    chk("R7 irq unmasked", 64'(irq), 1);
    wr(4, C_MASK, 10'h000);
    pad = '0; wait_n(4); wr_all(C_STAT, ONES);

    // R6 event and clear on the same edge
    pad = 42'd1 << 3;
    @(negedge clk); @(negedge clk);
    req = 1; we = 1; addr = {3'd0, 3'(C_STAT)}; wdata = 10'h008;
    @(negedge clk); req = 0; we = 0;
    rd(0, C_STAT, d); chk("R6 set beats clear", 64'(d), 64'h8);
    wr(0, C_STAT, 10'h008);
    rd(0, C_STAT, d); chk("R6 later clear", 64'(d), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule